// File: doc/BRIEF.md
# Receive Character Queue with Threshold and Idle Timeout

This block sits behind an asynchronous serial deserializer and buffers up to sixteen received characters, each stored together with its parity, framing and break flags. The host pops characters from the head. Two attention signals tell the host when to read. The first is a threshold indication, raised when the fill level reaches one of four selectable levels. The second is a timeout indication, raised when characters have sat in the queue for four character times with no new arrival and no host read.

Character timing comes from a baud-tick input together with a character-length setting, given as baud ticks per character. The deserializer and the baud generator are outside the block. A status bit reports whether any stored character still carries an error.

The queue has three operating conditions. In queue mode with interrupts enabled, both attention signals work. In polled mode, the queue stores characters in the same way but both attention signals stay low. In character mode, the queue shrinks to a single holding register.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: In queue mode (`fifo_on`=1) up to 16 characters are held and popped in arrival order. `fill` gives the number held. A write that arrives while 16 are held, with no pop in the same cycle, is dropped.
- R2: `trig_sel` selects the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Once the first-byte delay of R4 has elapsed, `thr_hit` is 1 while `fill` is at or above the threshold, provided `int_en`=1 and `fifo_on`=1.
- R3: `thr_hit` drops in the same cycle that a pop brings `fill` below the threshold.
- R4: A write into an empty queue holds `thr_hit` low for 3 clock cycles. After the write edge, `thr_hit` is still 0 at the samples taken 0, 1 and 2 cycles later, and can first be 1 at the sample taken 3 cycles later.
- R5: `to_pend` is set when the queue is non-empty and 4×`char_len` baud ticks have passed with no write and no pop, followed by 8 further clock cycles. The flag is 1 at the sample taken 8 cycles after the edge of the expiring tick, and 0 at the sample taken 7 cycles after it.
- R6: Any accepted write or pop restarts the idle count from zero.
- R7: A pop clears `to_pend` on the next edge.
- R8: With `int_en`=0 (polled mode), `thr_hit` and `to_pend` stay 0, while storage and `fill` work as in R1.
- R9: `fifo_err` is 1 while at least one held character carries an error flag, and returns to 0 once the last such character has been popped. `rd_flags` shows the flags of the head character, with bit 2 for break, bit 1 for framing and bit 0 for parity.
- R10: In character mode (`fifo_on`=0) a write overwrites a single holding register, so `fill` is at most 1. In this mode `fifo_err`, `thr_hit` and `to_pend` are 0. Any change of `fifo_on` empties the queue.
- R11: `flush` empties the queue and clears `fifo_err` and `to_pend`. The character-length setting is not affected, so the timeout works again after a flush.
- R12: After reset, `fill` is 0 and `data_ready`, `thr_hit`, `to_pend` and `fifo_err` are all 0. `data_ready` is 1 whenever `fill` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_on | input | 1 | 1 selects queue mode, 0 selects single holding register |
| int_en | input | 1 | Enables the threshold and timeout indications |
| trig_sel | input | 2 | Threshold select code |
| char_len | input | 4 | Baud ticks per character |
| flush | input | 1 | Empties the queue |
| baud_tick | input | 1 | One-cycle pulse per baud period |
| wr_en | input | 1 | Received-character strobe |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error on the received character |
| wr_ferr | input | 1 | Framing error on the received character |
| wr_brk | input | 1 | Break detected on the received character |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Head character |
| rd_flags | output | 3 | Head error flags {break, framing, parity} |
| fill | output | 5 | Number of held characters |
| data_ready | output | 1 | Queue non-empty |
| thr_hit | output | 1 | Threshold reached |
| to_pend | output | 1 | Character timeout pending |
| fifo_err | output | 1 | Some held character carries an error |

## Verification
The hardest condition to reach is a timeout that must not fire: enough total baud ticks pass to exceed the limit, but a write or a pop in the middle of them restarts the count. The stimulus spaces the ticks by hand, first with a write placed one tick short of the limit and then with a pop placed the same way. It then lets the queue sit idle, so that a missed restart would show up as a raised `to_pend`. After that it applies the single final tick and counts clock cycles to the exact sample at which the flag must first be seen.

// File: rtl/rxq_pkg.sv
// Shared types and the threshold encoding for the receive character queue.
// Assumes the threshold values fit into the fill counter of the queue.
package rxq_pkg;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rxq_flags_t;

    // Maps the two-bit threshold select code to a character count.
    function automatic int thr_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Character storage: circular buffer with pointers, fill count and a count
// of held entries that carry an error flag. In character mode it acts as a
// one-entry holding register. Assumes DEPTH is a power of two.
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                fifo_on,
    input  logic                push,
    input  logic                pop,
    input  logic [DATA_W-1:0]   in_data,
    input  rxq_pkg::rxq_flags_t in_flags,
    output logic [DATA_W-1:0]   head_data,
    output rxq_pkg::rxq_flags_t head_flags,
    output logic [CNT_W-1:0]    count,
    output logic                any_err
);
    logic [DATA_W-1:0]   mem_d [DEPTH];
    rxq_pkg::rxq_flags_t mem_f [DEPTH];
    logic [PTR_W-1:0]    wptr, rptr;
    logic [CNT_W-1:0]    err_cnt;
    logic                in_bad, head_bad;

    assign in_bad     = |in_flags;
    assign head_bad   = |mem_f[rptr];
    assign head_data  = mem_d[rptr];
    assign head_flags = mem_f[rptr];
    assign any_err    = (err_cnt != '0);

    // Entry write: queue mode appends at wptr, character mode overwrites head.
    always_ff @(posedge clk) begin
        if (push) begin
            if (fifo_on) begin
                mem_d[wptr] <= in_data;
                mem_f[wptr] <= in_flags;
            end else begin
                mem_d[rptr] <= in_data;
                mem_f[rptr] <= in_flags;
            end
        end
    end

    // Pointer, fill count and error count maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else if (!fifo_on) begin
            if (push) begin
                count   <= CNT_W'(1);
                err_cnt <= '0;
            end else if (pop) begin
                count   <= '0;
            end
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            count   <= count + CNT_W'(push) - CNT_W'(pop);
            err_cnt <= err_cnt + CNT_W'(push && in_bad) - CNT_W'(pop && head_bad);
        end
    end

endmodule

// File: rtl/rxq_thresh.sv
// Threshold comparator with a hold-off after a write into an empty queue.
// Assumes `clr` empties the queue on the same edge it is applied.
module rxq_thresh #(
    parameter int DEPTH     = 16,
    parameter int FIRST_DLY = 3,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int HLD_W    = $clog2(FIRST_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             first_push,
    input  logic             enable,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] count,
    output logic             thr_hit
);
    logic [HLD_W-1:0] hold;
    logic [CNT_W-1:0] thr_lvl;

    assign thr_lvl = CNT_W'(rxq_pkg::thr_of(trig_sel));
    assign thr_hit = enable && (hold == '0) && (count >= thr_lvl);

    // Hold-off counter loaded by the first character into an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        hold <= '0;
        else if (first_push)      hold <= HLD_W'(FIRST_DLY);
        else if (hold != '0)      hold <= hold - 1'b1;
    end

endmodule

// File: rtl/rxq_idle_timer.sv
// Idle timer: counts baud ticks while the queue holds data with no activity,
// then waits a fixed number of clocks before flagging a timeout. A pop clears
// the flag. Assumes baud_tick is a single-cycle pulse.
module rxq_idle_timer #(
    parameter int CHAR_W     = 4,
    parameter int TOUT_CHARS = 4,
    parameter int TOUT_DLY   = 8,
    localparam int LIM_W     = CHAR_W + $clog2(TOUT_CHARS + 1),
    localparam int DLY_W     = $clog2(TOUT_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              armed,
    input  logic              int_en,
    input  logic              nonempty,
    input  logic              push,
    input  logic              pop,
    input  logic              baud_tick,
    input  logic [CHAR_W-1:0] char_len,
    output logic              pending
);
    logic [LIM_W-1:0] ticks;
    logic [LIM_W-1:0] limit;
    logic [DLY_W-1:0] dly;
    logic             expired;

    assign limit   = LIM_W'(TOUT_CHARS) * LIM_W'(char_len);
    assign expired = (limit != '0) && (ticks >= limit);

    // Tick counting, post-expiry delay and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !armed || !nonempty) begin
            ticks   <= '0;
            dly     <= '0;
            pending <= 1'b0;
        end else if (push || pop) begin
            ticks <= '0;
            dly   <= '0;
            if (pop) pending <= 1'b0;
        end else if (!expired) begin
            if (baud_tick) ticks <= ticks + 1'b1;
        end else if (!pending) begin
            if (dly == DLY_W'(TOUT_DLY - 1)) begin
                pending <= int_en;
                dly     <= '0;
            end else begin
                dly <= dly + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_trigger_fifo.sv
// Receive character queue top: storage, threshold and idle timeout. It
// decides push/pop acceptance and empties itself on a flush or a mode change.
// Assumes one character strobe per cycle at most.
module rxq_trigger_fifo #(
    parameter int DEPTH      = 16,
    parameter int DATA_W     = 8,
    parameter int CHAR_W     = 4,
    parameter int TOUT_CHARS = 4,
    parameter int FIRST_DLY  = 3,
    parameter int TOUT_DLY   = 8,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_on,
    input  logic              int_en,
    input  logic [1:0]        trig_sel,
    input  logic [CHAR_W-1:0] char_len,
    input  logic              flush,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_perr,
    input  logic              wr_ferr,
    input  logic              wr_brk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        rd_flags,
    output logic [CNT_W-1:0]  fill,
    output logic              data_ready,
    output logic              thr_hit,
    output logic              to_pend,
    output logic              fifo_err
);
    logic                fifo_on_q, clr, push, pop, full, any_err, pend_raw, thr_raw;
    rxq_pkg::rxq_flags_t in_flags, head_flags;

    assign in_flags   = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr};
    assign full       = (fill == CNT_W'(DEPTH));
    assign pop        = rd_en && data_ready;
    assign push       = wr_en && (!fifo_on || !full || pop);
    assign clr        = flush || (fifo_on != fifo_on_q);
    assign data_ready = (fill != '0);
    assign rd_flags   = head_flags;
    assign fifo_err   = fifo_on && any_err;
    assign thr_hit    = fifo_on && thr_raw;
    assign to_pend    = fifo_on && int_en && pend_raw;

    // Remembers the previous mode to detect a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_on_q <= 1'b0;
        else        fifo_on_q <= fifo_on;
    end

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fifo_on(fifo_on),
        .push(push), .pop(pop), .in_data(wr_data), .in_flags(in_flags),
        .head_data(rd_data), .head_flags(head_flags), .count(fill),
        .any_err(any_err)
    );

    rxq_thresh #(.DEPTH(DEPTH), .FIRST_DLY(FIRST_DLY)) u_thresh (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .first_push(push && !data_ready),
        .enable(int_en), .trig_sel(trig_sel), .count(fill),
        .thr_hit(thr_raw)
    );

    rxq_idle_timer #(.CHAR_W(CHAR_W), .TOUT_CHARS(TOUT_CHARS), .TOUT_DLY(TOUT_DLY)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .armed(fifo_on), .int_en(int_en),
        .nonempty(data_ready), .push(push), .pop(pop), .baud_tick(baud_tick),
        .char_len(char_len), .pending(pend_raw)
    );

endmodule

// File: rtl/rxq_trigger_fifo_chk.sv
// Property checker for the receive character queue, bound to the top module.
module rxq_trigger_fifo_chk #(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_on,
    input logic             int_en,
    input logic             flush,
    input logic             wr_en,
    input logic             rd_en,
    input logic [CNT_W-1:0] fill,
    input logic             thr_hit,
    input logic             to_pend,
    input logic             fifo_err
);
    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && $stable(fifo_on) && !flush && fill == CNT_W'(DEPTH) && wr_en && !rd_en)
        |=> fill == CNT_W'(DEPTH));

    p_first_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill == '0 && fifo_on) |=> !thr_hit);

    p_read_clears_to_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fill != '0 && to_pend) |=> !to_pend);

    p_polled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> (!thr_hit && !to_pend));

    p_char_noerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> !fifo_err);

    p_char_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |=> (fifo_on || fill <= CNT_W'(1)));

    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0 && !to_pend && !fifo_err));

endmodule

bind rxq_trigger_fifo rxq_trigger_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rxq_trigger_fifo_bench.sv
// Directed bench for the receive character queue: one task per scenario.
module rxq_trigger_fifo_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, fifo_on, int_en, flush, baud_tick, wr_en, rd_en;
    logic       wr_perr, wr_ferr, wr_brk;
    logic [1:0] trig_sel;
    logic [3:0] char_len;
    logic [7:0] wr_data, rd_data;
    logic [2:0] rd_flags;
    logic [4:0] fill;
    logic       data_ready, thr_hit, to_pend, fifo_err;
    int         n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_trigger_fifo u_rxq_trigger_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .int_en(int_en),
        .trig_sel(trig_sel), .char_len(char_len), .flush(flush),
        .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en),
        .rd_data(rd_data), .rd_flags(rd_flags), .fill(fill),
        .data_ready(data_ready), .thr_hit(thr_hit), .to_pend(to_pend),
        .fifo_err(fifo_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f);
        wr_en = 1'b1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f;
        @(negedge clk);
        wr_en = 1'b0; {wr_brk, wr_ferr, wr_perr} = 3'b000;
    endtask

    task automatic pop();
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0;
        end
    endtask

    task automatic do_flush();
        flush = 1'b1; @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 fill", fill, 0);
        chk("R12 data_ready", data_ready, 0);
        chk("R12 thr_hit", thr_hit, 0);
        chk("R12 to_pend", to_pend, 0);
        chk("R12 fifo_err", fifo_err, 0);
    endtask

    task automatic t_order_polled();
        int_en = 1'b0; trig_sel = 2'b00; do_flush();
        for (int i = 0; i < 17; i++) push(8'h30 + 8'(i), 3'b000);
        chk("R1 fill at capacity", fill, 16);
        chk("R12 data_ready", data_ready, 1);
        cyc(4);
        chk("R8 thr_hit polled", thr_hit, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R1 order", rd_data, 8'h30 + i);
            pop();
        end
        chk("R1 drained, overflow dropped", fill, 0);
    endtask

    task automatic t_thresholds();
        int lv;
        int_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s); do_flush();
            lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            for (int i = 0; i < lv - 1; i++) push(8'(i), 3'b000);
            cyc(4);
            chk("R2 below threshold", thr_hit, 0);
            push(8'hEE, 3'b000);
            cyc(3);
            chk("R2 at threshold", thr_hit, 1);
            pop();
            chk("R3 below after pop", thr_hit, 0);
        end
        do_flush();
    endtask

    task automatic t_first_delay();
        int_en = 1'b1; trig_sel = 2'b00; do_flush();
        push(8'h5A, 3'b000);
        chk("R4 +0", thr_hit, 0);
        cyc(1); chk("R4 +1", thr_hit, 0);
        cyc(1); chk("R4 +2", thr_hit, 0);
        cyc(1); chk("R4 +3", thr_hit, 1);
        do_flush();
    endtask

    task automatic t_timeout();
        int_en = 1'b1; trig_sel = 2'b11; char_len = 4'd2; do_flush();
        push(8'hA1, 3'b000);
        tick(7);
        push(8'hA2, 3'b000);
        tick(7); cyc(20);
        chk("R6 write restarts", to_pend, 0);
        pop();
        tick(7); cyc(20);
        chk("R6 read restarts", to_pend, 0);
        tick(1); cyc(7);
        chk("R5 not yet", to_pend, 0);
        cyc(1);
        chk("R5 raised", to_pend, 1);
        pop();
        chk("R7 read clears", to_pend, 0);
        push(8'hB1, 3'b000);
        tick(8); cyc(8);
        chk("R5 raised again", to_pend, 1);
        push(8'hB2, 3'b001);
        do_flush();
        chk("R11 fill", fill, 0);
        chk("R11 to_pend", to_pend, 0);
        chk("R11 fifo_err", fifo_err, 0);
        push(8'hB3, 3'b000);
        tick(8); cyc(8);
        chk("R11 length kept", to_pend, 1);
        do_flush();
    endtask

    task automatic t_errors();
        int_en = 1'b0; do_flush();
        push(8'h11, 3'b000);
        push(8'h22, 3'b001);
        push(8'h33, 3'b100);
        chk("R9 err set", fifo_err, 1);
        chk("R9 head flags", rd_flags, 0);
        pop();
        chk("R9 err held", fifo_err, 1);
        chk("R9 head data", rd_data, 8'h22);
        chk("R9 parity flag", rd_flags, 1);
        pop();
        chk("R9 break flag", rd_flags, 4);
        chk("R9 err still held", fifo_err, 1);
        pop();
        chk("R9 err cleared", fifo_err, 0);
    endtask

    task automatic t_charmode();
        push(8'h77, 3'b000); push(8'h78, 3'b000);
        fifo_on = 1'b0; int_en = 1'b1; trig_sel = 2'b00; char_len = 4'd2;
        cyc(1);
        chk("R10 mode change empties", fill, 0);
        push(8'h41, 3'b000);
        push(8'h42, 3'b010);
        chk("R10 single entry", fill, 1);
        chk("R10 overwrite", rd_data, 8'h42);
        chk("R10 err masked", fifo_err, 0);
        tick(8); cyc(12);
        chk("R10 no thr_hit", thr_hit, 0);
        chk("R10 no to_pend", to_pend, 0);
        pop();
        chk("R10 read empties", fill, 0);
        fifo_on = 1'b1; cyc(1);
    endtask

    initial begin
        rst_n = 1'b0; fifo_on = 1'b1; int_en = 1'b0; flush = 1'b0;
        baud_tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        wr_perr = 1'b0; wr_ferr = 1'b0; wr_brk = 1'b0;
        trig_sel = 2'b00; char_len = 4'd2;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_order_polled();
        t_thresholds();
        t_first_delay();
        t_timeout();
        t_errors();
        t_charmode();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule